// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received frame bytes into a ring of buffer descriptors kept in system memory. Each descriptor is two 32-bit little-endian words. The first word carries a word-aligned buffer address and two control flags. The second word is a status word that the block fills in. Bytes enter one at a time on a valid/ready stream whose final byte carries an end flag. The block waits until the first byte of a frame is offered and then fetches the descriptor at its current ring position. If software still owns that descriptor, the block writes up to 128 frame bytes into its buffer, writes the status word, and sets the ownership flag to hand the descriptor back. It then steps to the next descriptor, and a long frame continues there.

The ring start is set by writing a pointer value, which loads both the base and the current position. The ring returns to its base when a descriptor's wrap flag is set, or when the current position sits a fixed span (8192 bytes by default) past the base. Two sticky flag pairs report the outcome of each frame: one pair for "no free buffer" and one for "frame stored". An interrupt output is raised by the interrupt flags that are enabled in a mask. Address filtering and the bus fabric lie outside this block.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `cur_ptr`, `rx_status` and `int_status` are zero, `irq` is low and `in_ready` is low. A cycle with `ptr_load` high loads `ptr_value` into both the ring base and `cur_ptr`, and the next descriptor fetch reads the word at that address.
- R2: Descriptor word 0 holds the buffer address in bits 31:2, the wrap flag in bit 1 and the ownership flag in bit 0 (0 = free for the block). Segment byte k is written to byte address buffer+k, as a word write to the aligned address, with byte enable bit (k mod 4) set and the byte on lane (k mod 4) (little-endian).
- R3: A descriptor buffer receives at most 128 bytes. A frame longer than that continues in the next descriptors in ring order, and a frame of exactly 128 bytes uses only one descriptor.
- R4: The status word (descriptor address + 4) of a segment has bit 14 set if the segment is the first of its frame. It has bit 15 set and the total frame length in bits 13:0 if the segment is the last. All other bits are zero, so a middle segment writes 0.
- R5: After the status word, word 0 is written back with bit 0 set and bits 31:1 unchanged.
- R6: After each handed-back descriptor, `cur_ptr` moves on by 8. It returns to the base instead when the descriptor's wrap flag is set, or when `cur_ptr` minus the base equals RING_SPAN before the step.
- R7: If a fetched descriptor has bit 0 = 1, that descriptor and its buffer are not written and `cur_ptr` is not moved. `rx_status[0]` and `int_status[0]` are set, and the remaining bytes of the frame up to and including the end-flagged byte are accepted and discarded.
- R8: When the last segment of a frame has been handed back, `rx_status[1]` and `int_status[1]` are set. No completion is flagged for an abandoned frame.
- R9: `irq` is high exactly while some bit of `int_status` is set together with the same bit of `irq_mask`. `sts_clr` and `int_clr` clear the flags whose bits they hold (write-one-to-clear), and a set in the same cycle takes priority.
- R10: A memory request keeps `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` stable until the cycle in which `mem_gnt` is high. Bytes are never accepted while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_load | input | 1 | Load ring base and current pointer |
| ptr_value | input | 32 | Ring start address (8-byte aligned) |
| in_valid | input | 1 | Frame byte offered |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Byte accepted on this edge when valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_gnt | input | 1 | Request completes on this edge |
| mem_rdata | input | 32 | Read data, valid while granted |
| irq_mask | input | 2 | Interrupt enables: bit 0 no buffer, bit 1 frame stored |
| sts_clr | input | 2 | Write-one-to-clear for rx_status |
| int_clr | input | 2 | Write-one-to-clear for int_status |
| rx_status | output | 2 | Sticky: bit 0 no buffer, bit 1 frame stored |
| int_status | output | 2 | Sticky interrupt flags, same bit meaning |
| irq | output | 1 | Masked interrupt request |
| cur_ptr | output | 32 | Current descriptor address |

## Verification
The bench goes after the segment boundaries: lengths of 127, 128, 129 and 300 bytes. A design that split at the wrong count would either open an empty extra descriptor for a 128-byte frame or overfill a buffer by one byte. Ring wrap is tested both by the span limit and by the descriptor flag, because a design that checked the offset after stepping would use one descriptor too few or too many. An owned descriptor is offered both at the start of a frame and mid-frame. The bench expects the rest of the frame to be drained, the pointer to stay put and no completion flag. A design that got this wrong would overwrite a buffer software still holds, or hang the byte stream. Masked interrupts and write-one-to-clear are checked to see that the flags and the line stay independent.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int WORD_W     = 32;
  localparam int LEN_W      = 14;   // length field bits 13:0 of the status word
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DATA,
    S_WBYTE,
    S_STAT,
    S_OWN,
    S_DRAIN
  } rxr_state_e;

  // Byte enable for one byte lane of a little-endian word.
  function automatic logic [3:0] lane_enable(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

  // Status word: bit 15 last segment, bit 14 first segment, 13:0 frame length on the last.
  function automatic logic [WORD_W-1:0] status_word(input logic first_seg,
                                                    input logic last_seg,
                                                    input logic [LEN_W-1:0] total);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[15]    = last_seg;
    w[14]    = first_seg;
    w[13:0]  = last_seg ? total : '0;
    return w;
  endfunction

  // Ring step: back to base on a wrap flag or when the span limit is reached.
  function automatic logic [WORD_W-1:0] ring_step(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] base,
                                                  input logic wrap_flag,
                                                  input logic [WORD_W-1:0] span);
    if (wrap_flag || ((cur - base) == span)) return base;
    return cur + WORD_W'(DESC_BYTES);
  endfunction

endpackage

// File: rtl/rxr_ptr_reg.sv
module rxr_ptr_reg
  import rxr_pkg::*;
#(
  parameter int RING_SPAN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              advance,
  input  logic              wrap_flag,
  output logic [WORD_W-1:0] cur,
  output logic [WORD_W-1:0] base
);

  localparam logic [WORD_W-1:0] SPAN_V = WORD_W'(RING_SPAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      base <= '0;
    end else if (load) begin
      cur  <= load_val;
      base <= load_val;
    end else if (advance) begin
      cur  <= ring_step(cur, base, wrap_flag, SPAN_V);
    end
  end

endmodule

// File: rtl/rxr_sticky.sv
module rxr_sticky #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int SEG_BYTES = 128,
  parameter int RING_SPAN = 8192,
  parameter int NUM_EV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [31:0]       ptr_value,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic [NUM_EV-1:0] irq_mask,
  input  logic [NUM_EV-1:0] sts_clr,
  input  logic [NUM_EV-1:0] int_clr,
  output logic [NUM_EV-1:0] rx_status,
  output logic [NUM_EV-1:0] int_status,
  output logic              irq,
  output logic [31:0]       cur_ptr
);

  localparam int SEG_W = $clog2(SEG_BYTES + 1);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_BYTES - 1);

  rxr_state_e        state_q, state_d;
  logic [WORD_W-1:0] desc_q;
  logic [SEG_W-1:0]  seg_q;
  logic [LEN_W-1:0]  len_q;
  logic              sof_q, eof_q, last_q;
  logic [7:0]        byte_q;
  logic [WORD_W-1:0] base_ptr;

  // Named internal events, used by the checker.
  logic ev_bna, ev_done, ev_handback, ev_byte_wr, ev_accept;
  logic [WORD_W-1:0] wr_byte_addr;

  assign ev_bna      = (state_q == S_FETCH) && mem_gnt && mem_rdata[0];
  assign ev_handback = (state_q == S_OWN) && mem_gnt;
  assign ev_done     = ev_handback && eof_q;
  assign ev_byte_wr  = (state_q == S_WBYTE) && mem_gnt;
  assign ev_accept   = in_valid && in_ready;

  assign wr_byte_addr = {desc_q[WORD_W-1:2], 2'b00} + WORD_W'(seg_q);
  assign in_ready     = (state_q == S_DATA) || (state_q == S_DRAIN);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = 4'h0;
    unique case (state_q)
      S_FETCH: mem_req = 1'b1;
      S_WBYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {wr_byte_addr[WORD_W-1:2], 2'b00};
        mem_wdata = {4{byte_q}};
        mem_be    = lane_enable(wr_byte_addr[1:0]);
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + 32'd4;
        mem_wdata = status_word(sof_q, eof_q, len_q);
        mem_be    = 4'hF;
      end
      S_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = desc_q | 32'd1;
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (in_valid) state_d = S_FETCH;
      S_FETCH: if (mem_gnt) state_d = mem_rdata[0] ? S_DRAIN : S_DATA;
      S_DATA:  if (in_valid) state_d = S_WBYTE;
      S_WBYTE: if (mem_gnt) state_d = (last_q || seg_q == SEG_LAST) ? S_STAT : S_DATA;
      S_STAT:  if (mem_gnt) state_d = S_OWN;
      S_OWN:   if (mem_gnt) state_d = eof_q ? S_IDLE : S_FETCH;
      S_DRAIN: if (in_valid && in_last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      desc_q  <= '0;
      seg_q   <= '0;
      len_q   <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      last_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) begin
        sof_q <= 1'b1;
        eof_q <= 1'b0;
        len_q <= '0;
      end
      if (state_q == S_FETCH && mem_gnt) begin
        desc_q <= mem_rdata;
        seg_q  <= '0;
      end
      if (state_q == S_DATA && in_valid) begin
        byte_q <= in_data;
        last_q <= in_last;
      end
      if (ev_byte_wr) begin
        seg_q <= seg_q + 1'b1;
        len_q <= len_q + 1'b1;
        if (last_q) eof_q <= 1'b1;
      end
      if (ev_handback) sof_q <= 1'b0;
    end
  end

  rxr_ptr_reg #(.RING_SPAN(RING_SPAN)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_value),
    .advance  (ev_handback),
    .wrap_flag(desc_q[1]),
    .cur      (cur_ptr),
    .base     (base_ptr)
  );

  logic [NUM_EV-1:0] ev_set;
  assign ev_set = NUM_EV'({ev_done, ev_bna});

  rxr_sticky #(.W(NUM_EV)) u_rx_sts (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(sts_clr), .q(rx_status)
  );

  rxr_sticky #(.W(NUM_EV)) u_int_sts (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(int_clr), .q(int_status)
  );

  assign irq = |(int_status & irq_mask);

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int SEG_BYTES = 128,
  parameter int SEG_W     = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        in_ready,
  input logic        ptr_load,
  input logic [31:0] cur_ptr,
  input logic [31:0] base_ptr,
  input logic [1:0]  rx_status,
  input logic [1:0]  int_status,
  input logic [1:0]  irq_mask,
  input logic        irq,
  input logic        ev_bna,
  input logic        ev_done,
  input logic        ev_handback,
  input logic        ev_byte_wr,
  input logic [SEG_W-1:0] seg_q
);

  // R10: request attributes hold until granted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                            && $stable(mem_we) && $stable(mem_be));

  // R10: no byte accepted while a request is outstanding
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && mem_req));

  // R3: a segment never exceeds its byte limit
  a_r3_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_wr |-> (32'(seg_q) < SEG_BYTES));

  // R2: each data write enables exactly one byte lane
  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_wr |-> $onehot0(mem_be) && (mem_be != 4'h0));

  // R5: hand-back writes word 0 of the current descriptor with ownership set
  a_r5_handback: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handback |-> mem_we && (mem_addr == cur_ptr) && mem_wdata[0]);

  // R6: the pointer steps by 8 or returns to base
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_handback && !ptr_load |=> (cur_ptr == base_ptr) || (cur_ptr == $past(cur_ptr) + 32'd8));

  // R7: no-buffer event raises both flags and leaves the pointer
  a_r7_bna_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bna && !ptr_load |=> rx_status[0] && int_status[0] && $stable(cur_ptr));

  // R8: completion raises both flags
  a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> rx_status[1] && int_status[1]);

  // R9: an enabled completion interrupt drives the line
  a_r9_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done && irq_mask[1] |=> irq || !irq_mask[1]);

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.SEG_BYTES(SEG_BYTES), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .in_ready(in_ready),
  .ptr_load(ptr_load), .cur_ptr(cur_ptr), .base_ptr(base_ptr), .rx_status(rx_status),
  .int_status(int_status), .irq_mask(irq_mask), .irq(irq), .ev_bna(ev_bna),
  .ev_done(ev_done), .ev_handback(ev_handback), .ev_byte_wr(ev_byte_wr), .seg_q(seg_q)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;

  localparam int SPAN  = 64;            // 9 descriptors before the span limit wraps
  localparam int SEG   = 128;
  localparam logic [31:0] BASE = 32'h400;
  localparam int MWORDS = 2048;
  // table: {frame length[11:0], expected descriptors[3:0]}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {12'd1, 4'd1}, {12'd4, 4'd1}, {12'd5, 4'd1}, {12'd60, 4'd1},
    {12'd127, 4'd1}, {12'd128, 4'd1}, {12'd129, 4'd2}, {12'd300, 4'd3}};

  logic clk = 0, rst_n = 0;
  logic ptr_load = 0; logic [31:0] ptr_value = 0;
  logic in_valid = 0, in_last = 0; logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, mem_gnt = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_ptr;
  logic [3:0] mem_be;
  logic [1:0] irq_mask = 0, sts_clr = 0, int_clr = 0, rx_status, int_status;

  logic [31:0] mem [MWORDS];
  int checks = 0, errors = 0, cyc = 0, idx = 0;
  bit stall = 0;

  always #2 clk = ~clk;

  rx_ring_writer #(.SEG_BYTES(SEG), .RING_SPAN(SPAN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_value(ptr_value),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq_mask(irq_mask),
    .sts_clr(sts_clr), .int_clr(int_clr), .rx_status(rx_status), .int_status(int_status),
    .irq(irq), .cur_ptr(cur_ptr));

  assign mem_rdata = mem[mem_addr[12:2]];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_gnt <= mem_req && (!stall || (cyc % 3 == 1));
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[12:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  function automatic logic [31:0] desc_a(input int i); return BASE + 32'(8 * i); endfunction
  function automatic logic [31:0] buf_a(input int i); return 32'h800 + 32'(256 * i); endfunction
  function automatic logic [7:0] fbyte(input int seed, input int j);
    return 8'(seed * 37 + j * 7 + 3);
  endfunction
  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[12:2]][8*a[1:0] +: 8];
  endfunction
  function automatic int ring_next(input int i);
    return (i * 8 == SPAN) ? 0 : i + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input int seed);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      in_valid = 1; in_data = fbyte(seed, j); in_last = (j == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_flags();
    for (int t = 0; t < 3000 && rx_status == 2'b00; t++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); sts_clr = 2'b11; int_clr = 2'b11;
    @(negedge clk); sts_clr = 2'b00; int_clr = 2'b00;
  endtask

  task automatic load_ptr(input logic [31:0] v);
    @(negedge clk); ptr_load = 1; ptr_value = v;
    @(negedge clk); ptr_load = 0;
  endtask

  task automatic arm_ring();
    for (int i = 0; i < 9; i++) begin
      mem[desc_a(i) >> 2] = buf_a(i);
      mem[(desc_a(i) + 4) >> 2] = 32'hDEAD_BEEF;
    end
  endtask

  // check all segments of a stored frame, re-arm them, advance model index
  task automatic verify_frame(input int len, input int seed, input int nseg, input string tag);
    for (int k = 0; k < nseg; k++) begin
      int first, cnt, bad;
      logic [31:0] st;
      first = k * SEG;
      cnt = (len - first > SEG) ? SEG : len - first;
      st = (k == 0) ? 32'h4000 : 32'h0;
      if (k == nseg - 1) st = st | 32'h8000 | 32'(len);
      check({tag, " R4 status"}, mem[(desc_a(idx) + 4) >> 2], st);
      check({tag, " R5 handback"}, mem[desc_a(idx) >> 2], buf_a(idx) | 32'd1);
      bad = 0;
      for (int j = 0; j < cnt; j++)
        if (rd_byte(buf_a(idx) + 32'(j)) !== fbyte(seed, first + j)) bad++;
      check({tag, " R2 R3 bytes"}, 32'(bad), 32'd0);
      mem[desc_a(idx) >> 2] = buf_a(idx);
      idx = ring_next(idx);
    end
  endtask

  initial begin
    for (int w = 0; w < MWORDS; w++) mem[w] = 32'hA5A5_A5A5;
    arm_ring();
    repeat (3) @(negedge clk);
    check("R1 reset rx_status", 32'(rx_status), 0);
    check("R1 reset int_status", 32'(int_status), 0);
    check("R1 reset irq/in_ready/req", {29'd0, irq, in_ready, mem_req}, 0);
    check("R1 reset cur_ptr", cur_ptr, 0);
    rst_n = 1;
    load_ptr(BASE);
    check("R1 ptr load", cur_ptr, BASE);
    irq_mask = 2'b11;

    // table walk: lengths around the segment size, span-limit wrap after 9 descriptors
    for (int v = 0; v < NV; v++) begin
      int len, ns;
      len = int'(VEC[v][15:4]); ns = int'(VEC[v][3:0]);
      stall = v[0];
      send_frame(len, v);
      wait_flags();
      check($sformatf("R8 vec%0d rx_status", v), 32'(rx_status), 32'd2);
      check($sformatf("R9 vec%0d irq", v), 32'(irq), 32'd1);
      verify_frame(len, v, ns, $sformatf("vec%0d", v));
      check($sformatf("R6 vec%0d cur_ptr", v), cur_ptr, desc_a(idx));
      clear_flags();
      check($sformatf("R9 vec%0d clear", v), {30'd0, irq, int_status[1]}, 0);
    end

    // R9 masked completion: flag set, line low
    irq_mask = 2'b01;
    send_frame(3, 20);
    wait_flags();
    check("R9 masked int_status", 32'(int_status), 32'd2);
    check("R9 masked irq low", 32'(irq), 32'd0);
    verify_frame(3, 20, 1, "mask");
    clear_flags();

    // R6 wrap flag on descriptor 1
    load_ptr(BASE); idx = 0;
    check("R1 reload cur_ptr", cur_ptr, BASE);
    mem[desc_a(1) >> 2] = buf_a(1) | 32'd2;
    irq_mask = 2'b11;
    send_frame(200, 21);
    wait_flags();
    check("R6 wrap flag returns to base", cur_ptr, BASE);
    check("R5 wrap bit kept", mem[desc_a(1) >> 2], buf_a(1) | 32'd3);
    check("R4 wrap frame last status", mem[(desc_a(1) + 4) >> 2], 32'h8000 | 32'd200);
    check("R4 wrap frame first status", mem[(desc_a(0) + 4) >> 2], 32'h4000);
    arm_ring();
    clear_flags();

    // R7 owned descriptor at frame start
    for (int w = 0; w < 32; w++) mem[(buf_a(0) >> 2) + w] = 32'hA5A5_A5A5;
    mem[desc_a(0) >> 2] = buf_a(0) | 32'd1;
    mem[(desc_a(0) + 4) >> 2] = 32'h1234_5678;
    irq_mask = 2'b01;
    stall = 1;
    send_frame(50, 22);
    wait_flags();
    check("R7 bna rx_status", 32'(rx_status), 32'd1);
    check("R7 bna irq", 32'(irq), 32'd1);
    check("R7 bna pointer kept", cur_ptr, BASE);
    check("R7 bna status untouched", mem[(desc_a(0) + 4) >> 2], 32'h1234_5678);
    check("R7 bna buffer untouched", mem[buf_a(0) >> 2], 32'hA5A5_A5A5);
    check("R7 bna frame drained", 32'(in_ready), 32'd0);
    clear_flags();

    // R7 owned descriptor mid-frame
    arm_ring();
    mem[desc_a(1) >> 2] = buf_a(1) | 32'd1;
    irq_mask = 2'b11;
    send_frame(200, 23);
    wait_flags();
    check("R7 mid-frame rx_status", 32'(rx_status), 32'd1);
    check("R4 R7 mid-frame first status", mem[(desc_a(0) + 4) >> 2], 32'h4000);
    check("R7 mid-frame pointer", cur_ptr, BASE + 32'd8);
    clear_flags();

    // recovery: re-arm descriptor 1 and store a short frame there
    mem[desc_a(1) >> 2] = buf_a(1);
    idx = 1;
    send_frame(10, 24);
    wait_flags();
    check("R8 recovery rx_status", 32'(rx_status), 32'd2);
    verify_frame(10, 24, 1, "recover");
    check("R6 recovery cur_ptr", cur_ptr, BASE + 32'd16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule